// File: doc/BRIEF.md
# Byte-Lane Read-Merge-Write Controller

This block connects a byte-addressed request port to a single-port, word-wide synchronous memory that has no per-byte write strobes. Each request carries a byte address, a size code (one, two or four bytes), a write flag and write data. The memory word index is the byte address with its two low bits dropped, and those two bits say where inside the 32-bit word the access lands. Byte order is little-endian: the lowest byte address sits in bits [7:0].

A read fetches the whole word and returns only the requested bytes. A write narrower than a word, or one not word-aligned, fetches the word, replaces the addressed lanes and stores the whole word back. When an access runs past the end of a word, the block runs a second read-and-merge pass on the next word. A four-byte write at an aligned address skips the read and becomes one plain word store. One request is handled at a time. A one-cycle completion pulse marks the end of each request.

Top module: `rmw_byte_ctrl`

## Requirements
- R1: After reset, req_ready_o is 1 and rsp_done_o and mem_en_o are 0.
- R2: The memory word index is the byte address shifted right by two. Byte address offset k within a word maps to word bits [8k+7:8k], so lower addresses sit in the lower bits.
- R3: Size codes are 0 for one byte, 1 for two bytes, and 2 or 3 for four bytes. A read returns byte i of the request, at address A+i, in rsp_rdata_o bits [8i+7:8i], and returns zero in every byte above the request size. rsp_rdata_o is valid while rsp_done_o is 1.
- R4: A write that fits in one word replaces only the addressed byte lanes. The other bytes of that word keep their earlier values.
- R5: A write that runs past a word end updates the upper lanes of word W and then the lower lanes of word W+1, which wraps at the top of memory. Each word gets its own read followed by its own write.
- R6: A read that runs past a word end fetches words W and W+1 and joins their bytes in address order.
- R7: A four-byte write at a word-aligned address makes exactly one memory write and no memory read.
- R8: rsp_done_o rises in the cycle after the request is accepted plus a fixed count of cycles. It is 2 cycles after acceptance for an aligned full write, 3 for a single-word access and 5 for an access spanning two words. Memory read data is used in the cycle after the read is issued.
- R9: req_ready_o is 0 from the cycle after acceptance through the done cycle. Requests presented in that time are ignored and change no memory content.
- R10: rsp_done_o is a single-cycle pulse, and req_ready_o is 1 again in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Controller idle, request taken this cycle if valid |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | ADDR_W | Byte address |
| req_size_i | input | 2 | Size code (0:1, 1:2, 2/3:4 bytes) |
| req_wdata_i | input | 32 | Write bytes, first byte in [7:0] |
| rsp_done_o | output | 1 | One-cycle completion pulse |
| rsp_rdata_o | output | 32 | Read result, valid with rsp_done_o |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write (read when 0) |
| mem_addr_o | output | ADDR_W-2 | Memory word index |
| mem_wdata_o | output | 32 | Full word to store |
| mem_rdata_i | input | 32 | Word from memory, one cycle after a read |

## Verification
The hardest case to reach is a write that spans two words. There, the second read must see the memory after the first merge has been stored, and the block must leave every lane outside the request untouched. The case only shows up at offsets 1 to 3 with sizes that run over, and at the last word, where the index wraps to zero. The stimulus sweeps every byte address of a 16-word memory with every size, and reads each write straight back. After every operation it compares the whole memory against a byte model. During each busy period it also drives a conflicting request that must be ignored.

// File: rtl/rmw_pkg.sv
package rmw_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned WORD_W = 8 * LANES;
  localparam int unsigned OFF_W  = $clog2(LANES);

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD1, ST_MG1, ST_RD2, ST_MG2, ST_WFULL, ST_DONE
  } rmw_state_e;

  function automatic logic [2:0] size_to_bytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/rmw_merge.sv
module rmw_merge
  import rmw_pkg::*;
(
  input  logic [WORD_W-1:0] rd_word_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [2:0]        nbytes_i,
  input  logic              hi_word_i,
  output logic [WORD_W-1:0] merged_o
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [3:0] pos, rel;
    logic       sel;
    always_comb begin
      pos = hi_word_i ? 4'(k + LANES) : 4'(k);
      rel = pos - {2'b00, off_i};
      sel = (pos >= {2'b00, off_i}) && (rel < {1'b0, nbytes_i});
      merged_o[8*k +: 8] = sel ? wdata_i[8*rel[OFF_W-1:0] +: 8] : rd_word_i[8*k +: 8];
    end
  end
endmodule

// File: rtl/rmw_extract.sv
module rmw_extract
  import rmw_pkg::*;
(
  input  logic [WORD_W-1:0] lo_i,
  input  logic [WORD_W-1:0] hi_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic [2:0]        nbytes_i,
  output logic [WORD_W-1:0] rdata_o
);
  logic [2*WORD_W-1:0] win;
  assign win = {hi_i, lo_i} >> {off_i, 3'b000};

  for (genvar i = 0; i < LANES; i++) begin : g_byte
    assign rdata_o[8*i +: 8] = (3'(i) < nbytes_i) ? win[8*i +: 8] : 8'h00;
  end
endmodule

// File: rtl/rmw_byte_ctrl.sv
module rmw_byte_ctrl
  import rmw_pkg::*;
#(
  parameter int unsigned ADDR_W = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_valid_i,
  output logic                 req_ready_o,
  input  logic                 req_write_i,
  input  logic [ADDR_W-1:0]    req_addr_i,
  input  logic [1:0]           req_size_i,
  input  logic [WORD_W-1:0]    req_wdata_i,
  output logic                 rsp_done_o,
  output logic [WORD_W-1:0]    rsp_rdata_o,
  output logic                 mem_en_o,
  output logic                 mem_we_o,
  output logic [ADDR_W-3:0]    mem_addr_o,
  output logic [WORD_W-1:0]    mem_wdata_o,
  input  logic [WORD_W-1:0]    mem_rdata_i
);
  localparam int unsigned WA_W = ADDR_W - OFF_W;

  rmw_state_e        st_q, st_d;
  logic [WA_W-1:0]   wa_q;
  logic [OFF_W-1:0]  off_q;
  logic [2:0]        nb_q;
  logic              we_q, span_q;
  logic [WORD_W-1:0] wd_q, lo_q, hi_q;

  logic              accept, full_wr, span_in;
  logic [2:0]        nb_in;
  logic [WORD_W-1:0] merged;

  assign nb_in   = size_to_bytes(req_size_i);
  assign accept  = req_valid_i && (st_q == ST_IDLE);
  assign full_wr = req_write_i && (req_addr_i[OFF_W-1:0] == '0) && (nb_in == 3'd4);
  assign span_in = ({2'b00, req_addr_i[OFF_W-1:0]} + {1'b0, nb_in}) > 4'(LANES);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_valid_i) st_d = full_wr ? ST_WFULL : ST_RD1;
      ST_RD1:   st_d = ST_MG1;
      ST_MG1:   st_d = span_q ? ST_RD2 : ST_DONE;
      ST_RD2:   st_d = ST_MG2;
      ST_MG2:   st_d = ST_DONE;
      ST_WFULL: st_d = ST_DONE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      wa_q   <= '0;
      off_q  <= '0;
      nb_q   <= '0;
      we_q   <= 1'b0;
      span_q <= 1'b0;
      wd_q   <= '0;
      lo_q   <= '0;
      hi_q   <= '0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        wa_q   <= req_addr_i[ADDR_W-1:OFF_W];
        off_q  <= req_addr_i[OFF_W-1:0];
        nb_q   <= nb_in;
        we_q   <= req_write_i;
        span_q <= span_in;
        wd_q   <= req_wdata_i;
      end
      if (st_q == ST_MG1) lo_q <= mem_rdata_i;
      if (st_q == ST_MG2) hi_q <= mem_rdata_i;
    end
  end

  rmw_merge u_merge (
    .rd_word_i (mem_rdata_i),
    .wdata_i   (wd_q),
    .off_i     (off_q),
    .nbytes_i  (nb_q),
    .hi_word_i (st_q == ST_MG2),
    .merged_o  (merged)
  );

  rmw_extract u_extract (
    .lo_i     (lo_q),
    .hi_i     (hi_q),
    .off_i    (off_q),
    .nbytes_i (nb_q),
    .rdata_o  (rsp_rdata_o)
  );

  // read issue, then store the merged word on the cycle the data returns
  always_comb begin
    mem_we_o = (st_q == ST_WFULL) || (we_q && ((st_q == ST_MG1) || (st_q == ST_MG2)));
    mem_en_o = mem_we_o || (st_q == ST_RD1) || (st_q == ST_RD2);
  end
  assign mem_addr_o  = ((st_q == ST_RD2) || (st_q == ST_MG2)) ? wa_q + 1'b1 : wa_q;
  assign mem_wdata_o = (st_q == ST_WFULL) ? wd_q : merged;
  assign req_ready_o = (st_q == ST_IDLE);
  assign rsp_done_o  = (st_q == ST_DONE);

  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!mem_en_o && !rsp_done_o));
  assert_full_write_direct_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && req_write_i && req_addr_i[OFF_W-1:0] == '0 && req_size_i[1])
    |=> (mem_en_o && mem_we_o));
  assert_read_then_merge_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && !mem_we_o) |=> !(mem_en_o && !mem_we_o));
  assert_busy_after_accept_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  assert_done_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_done_o |=> (!rsp_done_o && req_ready_o));
  assert_second_word_next_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && !mem_we_o && !$past(req_ready_o) && $past(mem_en_o))
    |-> (mem_addr_o == $past(mem_addr_o) + 1'b1));
endmodule

// File: tb/sim_rmw_byte_ctrl.sv
`timescale 1ns/1ps
module sim_rmw_byte_ctrl;
  localparam int ADDR_W = 6;
  localparam int NBYTE  = 1 << ADDR_W;
  localparam int NWORD  = NBYTE / 4;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, done, mem_en, mem_we;
  logic [31:0] rdata, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic [ADDR_W-3:0] mem_addr;

  logic [31:0] mem [NWORD];
  logic [7:0]  ref_b [NBYTE];
  int checks = 0, errors = 0, rd_cnt = 0, wr_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rmw_byte_ctrl #(.ADDR_W(ADDR_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_size_i(req_size),
    .req_wdata_i(req_wdata), .rsp_done_o(done), .rsp_rdata_o(rdata),
    .mem_en_o(mem_en), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) begin mem[mem_addr] <= mem_wdata; wr_cnt++; end
      else begin mem_rdata <= mem[mem_addr]; rd_cnt++; end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_mem(input string req);
    bit ok = 1;
    for (int w = 0; w < NWORD; w++) begin
      logic [31:0] e = {ref_b[4*w+3], ref_b[4*w+2], ref_b[4*w+1], ref_b[4*w]};
      if (mem[w] !== e) begin
        ok = 0;
        $display("FAIL %s word %0d actual=%h expected=%h", req, w, mem[w], e);
      end
    end
    checks++;
    if (!ok) errors++;
  endtask

  task automatic do_op(input bit wr, input int a, input int sc, input logic [31:0] d,
                       output logic [31:0] got, output int cyc);
    @(negedge clk);
    check("R1 ready before request", 32'(req_ready), 32'd1);
    rd_cnt = 0; wr_cnt = 0;
    req_valid = 1'b1; req_write = wr; req_addr = ADDR_W'(a);
    req_size = 2'(sc); req_wdata = d;
    @(negedge clk);
    // conflicting request held during busy time (R9)
    req_write = 1'b1; req_addr = ADDR_W'(a ^ 1); req_size = 2'd2; req_wdata = ~d;
    cyc = 1;
    while (!done && cyc < 20) begin
      check("R9 ready low while busy", 32'(req_ready), 32'd0);
      @(negedge clk);
      cyc++;
    end
    got = rdata;
    req_valid = 1'b0;
    @(negedge clk);
    check("R10 done single pulse", {30'd0, done, req_ready}, 32'd1);
  endtask

  initial begin
    logic [31:0] got, d, e;
    int cyc, n, ecyc, erd, ewr, off;
    bit span;
    for (int i = 0; i < NBYTE; i++) ref_b[i] = 8'(i * 37 + 5);
    for (int w = 0; w < NWORD; w++)
      mem[w] = {ref_b[4*w+3], ref_b[4*w+2], ref_b[4*w+1], ref_b[4*w]};
    #1;
    check("R1 reset ready", 32'(req_ready), 32'd1);
    check("R1 reset done", 32'(done), 32'd0);
    check("R1 reset mem_en", 32'(mem_en), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int a = 0; a < NBYTE; a++) begin
      for (int sc = 0; sc < 4; sc++) begin
        n = (sc == 0) ? 1 : (sc == 1) ? 2 : 4;
        off = a % 4;
        span = (off + n) > 4;
        d = 32'h9E3779B9 * 32'(a * 4 + sc + 1) ^ 32'h5A5A0F0F;
        do_op(1'b1, a, sc, d, got, cyc);
        for (int i = 0; i < n; i++) ref_b[(a + i) % NBYTE] = d[8*i +: 8];
        if (off == 0 && n == 4) begin ecyc = 2; erd = 0; ewr = 1; end
        else if (span) begin ecyc = 5; erd = 2; ewr = 2; end
        else begin ecyc = 3; erd = 1; ewr = 1; end
        check(span ? "R5 write latency" : "R8 write latency", 32'(cyc), 32'(ecyc));
        check((ecyc == 2) ? "R7 full write reads/writes" : "R5 R4 reads/writes",
              32'(rd_cnt * 16 + wr_cnt), 32'(erd * 16 + ewr));
        check_mem(span ? "R5 spanning write" : "R4 R2 partial write");
        do_op(1'b0, a, sc, 32'h0, got, cyc);
        e = '0;
        for (int i = 0; i < n; i++) e[8*i +: 8] = ref_b[(a + i) % NBYTE];
        check(span ? "R6 spanning read data" : "R3 R2 read data", got, e);
        check("R8 read latency", 32'(cyc), span ? 32'd5 : 32'd3);
        check("R3 read has no writes", 32'(wr_cnt), 32'd0);
        check_mem("R9 busy request ignored");
      end
    end
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule